// File: doc/BRIEF.md
# Buffered PWM Compare Output Channel

This block is one output-compare channel that sits beside a timer counter. It holds an active compare value and a shadow (buffer) value. It watches the counter value and a set of strobes from the counter: start, stop, period match, overflow, underflow, clear, peak and valley. From these it maintains a single output level and drives it onto a PWM pin.

Each of four counter states has its own 2-bit action that the level follows. The states are counting started, counting stopped, compare match and period match. A force request can pin the level high or low, but it acts only at the next cycle boundary. The shadow value moves into the active compare register at a point picked by the counting shape. In sawtooth mode that point is overflow, underflow or clear. In triangle mode it is a selectable peak and/or valley.

A compare match sets a sticky flag. The flag, masked by its own enable, drives an interrupt line. A separate one-cycle event pulse, with its own enable, marks each match.

Top module: `bpwm_channel`

## Requirements
- R1: While reset is asserted and right after it, `pwm_o`, `flag_o`, `irq_o` and `evt_o` are 0 and `cmp_val_o` is 0.
- R2: On a compare match the level follows `act_cmp`, with the encoding 0 = low, 1 = high, 2 = hold, 3 = invert; the new level is visible after the clock edge that sees the match.
- R3: On `cnt_start` the level follows `act_start`. When `div1` is 0, the codes 0 (low) and 1 (high) act as hold, and only 2 (hold) and 3 (invert) take effect.
- R4: On `cnt_stop` the level follows `act_stop`, and on `prd_hit` it follows `act_prd`, using the same encoding as R2.
- R5: When several strobes fall in one cycle, their actions apply in this order: start, compare, period, stop. So with compare and period matching together, the period action acts on the result of the compare action.
- R6: `force_sel` encodes 0 = none, 1 = force low, 2 = force high, 3 = none. The forced level is applied only at a cycle boundary and overrides every other action of that cycle. A boundary is `ovf` or `udf` with `tri_mode`=0, or `valley` with `tri_mode`=1.
- R7: With `buf_en`=1 and `tri_mode`=0, the buffer is copied to the active compare value on `ovf`, on `udf` or on `cnt_clr`.
- R8: With `buf_en`=1 and `tri_mode`=1, `tri_sel` bit 0 enables transfer at `peak` and bit 1 enables transfer at `valley`. Overflow, underflow and clear then do not transfer.
- R9: A `cmp_wr` write takes effect in the active compare value at the next edge, whatever `buf_en` is, and takes priority over a transfer. With `buf_en`=0 no transfer ever happens.
- R10: A compare match is `cnt_tick` high with `cnt_val` equal to the active compare value. It sets `flag_o`, which stays set until `flag_clr`. A match in the same cycle as `flag_clr` wins.
- R11: `irq_o` is `flag_o` masked by `irq_en`. `evt_o` is a one-cycle pulse after each match while `evt_en` is 1.
- R12: `pwm_o` is 0 while `out_en` is 0, and the internal level keeps following the actions. Re-enabling shows the updated level at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CNT_W | Current counter value |
| cnt_tick | input | 1 | Counter presents a new value this cycle |
| cnt_start | input | 1 | Counting started strobe |
| cnt_stop | input | 1 | Counting stopped strobe |
| prd_hit | input | 1 | Period match strobe |
| ovf | input | 1 | Overflow strobe |
| udf | input | 1 | Underflow strobe |
| cnt_clr | input | 1 | Counter cleared strobe |
| peak | input | 1 | Triangle peak strobe |
| valley | input | 1 | Triangle valley strobe |
| tri_mode | input | 1 | 1 = triangle counting, 0 = sawtooth |
| div1 | input | 1 | Counter prescaler is divide-by-one |
| act_start | input | 2 | Action at start |
| act_stop | input | 2 | Action at stop |
| act_cmp | input | 2 | Action at compare match |
| act_prd | input | 2 | Action at period match |
| force_sel | input | 2 | Force request |
| out_en | input | 1 | Pin output enable |
| buf_en | input | 1 | Buffer transfer enable |
| tri_sel | input | 2 | Triangle transfer point select |
| cmp_wr | input | 1 | Write active compare value |
| cmp_wdata | input | CNT_W | Data for cmp_wr |
| buf_wr | input | 1 | Write buffer value |
| buf_wdata | input | CNT_W | Data for buf_wr |
| flag_clr | input | 1 | Clear the match flag |
| irq_en | input | 1 | Interrupt enable |
| evt_en | input | 1 | Event enable |
| pwm_o | output | 1 | PWM pin |
| cmp_val_o | output | CNT_W | Active compare value |
| flag_o | output | 1 | Sticky compare-match flag |
| irq_o | output | 1 | Interrupt request |
| evt_o | output | 1 | Compare-match event pulse |

## Verification
The hardest situation to reach is one where several strobes land in the same cycle and their relative order decides the level. A compare match together with a period match, or a forced boundary together with a period action, are such cases. The stimulus drives these strobes together in one cycle. It picks action pairs, such as high-then-invert against invert-then-high, whose results differ under the wrong order. Buffer transfers are told apart by writing a distinct shadow value before each candidate strobe. The active value is then read back, so a missed or spurious transfer shows up directly.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;
  typedef enum logic [1:0] {
    ACT_LOW  = 2'd0,
    ACT_HIGH = 2'd1,
    ACT_HOLD = 2'd2,
    ACT_INV  = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    FRC_NONE = 2'd0,
    FRC_LOW  = 2'd1,
    FRC_HIGH = 2'd2,
    FRC_RSVD = 2'd3
  } frc_e;

  function automatic logic apply_act(input act_e a, input logic cur);
    logic r;
    case (a)
      ACT_LOW:  r = 1'b0;
      ACT_HIGH: r = 1'b1;
      ACT_HOLD: r = cur;
      default:  r = ~cur;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bpwm_cmp.sv
module bpwm_cmp #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_tick,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             buf_wr,
  input  logic [CNT_W-1:0] buf_wdata,
  input  logic             buf_en,
  input  logic             tri_mode,
  input  logic [1:0]       tri_sel,
  input  logic             ovf,
  input  logic             udf,
  input  logic             cnt_clr,
  input  logic             peak,
  input  logic             valley,
  output logic [CNT_W-1:0] cmp_act,
  output logic             match
);
  logic [CNT_W-1:0] act_q, act_d;
  logic [CNT_W-1:0] shd_q, shd_d;
  logic             xfer_saw, xfer_tri, xfer;

  always_comb begin
    xfer_saw = ~tri_mode & (ovf | udf | cnt_clr);
    xfer_tri = tri_mode & ((peak & tri_sel[0]) | (valley & tri_sel[1]));
    xfer     = buf_en & (xfer_saw | xfer_tri);
    act_d    = act_q;
    if (cmp_wr)    act_d = cmp_wdata;
    else if (xfer) act_d = shd_q;
    shd_d    = buf_wr ? buf_wdata : shd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      shd_q <= '0;
    end else begin
      act_q <= act_d;
      shd_q <= shd_d;
    end
  end

  assign cmp_act = act_q;
  assign match   = cnt_tick & (cnt_val == act_q);

  // R9: without buffering and without a write the active value never moves
  a_r9_unbuffered_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_en && !cmp_wr) |=> $stable(cmp_act));

  // R7: sawtooth overflow with buffering loads the shadow value
  a_r7_saw_overflow_load: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && !tri_mode && ovf && !cmp_wr) |=> (cmp_act == $past(shd_q)));
endmodule

// File: rtl/bpwm_pol.sv
module bpwm_pol
  import bpwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_start,
  input  logic       cnt_stop,
  input  logic       cmp_hit,
  input  logic       prd_hit,
  input  logic       ovf,
  input  logic       udf,
  input  logic       valley,
  input  logic       tri_mode,
  input  logic       div1,
  input  logic [1:0] act_start,
  input  logic [1:0] act_stop,
  input  logic [1:0] act_cmp,
  input  logic [1:0] act_prd,
  input  logic [1:0] force_sel,
  output logic       level
);
  logic level_q, level_d;
  act_e start_eff;
  logic bnd;
  frc_e frc;

  always_comb begin
    start_eff = act_e'(act_start);
    if (!div1 && (start_eff == ACT_LOW || start_eff == ACT_HIGH))
      start_eff = ACT_HOLD;
    bnd = tri_mode ? valley : (ovf | udf);
    frc = frc_e'(force_sel);

    level_d = level_q;
    if (cnt_start) level_d = apply_act(start_eff, level_d);
    if (cmp_hit)   level_d = apply_act(act_e'(act_cmp), level_d);
    if (prd_hit)   level_d = apply_act(act_e'(act_prd), level_d);
    if (cnt_stop)  level_d = apply_act(act_e'(act_stop), level_d);
    if (bnd && frc == FRC_LOW)  level_d = 1'b0;
    if (bnd && frc == FRC_HIGH) level_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_d;
  end

  assign level = level_q;

  // R2: with no strobe at all the level stays put
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_start || cnt_stop || cmp_hit || prd_hit || ovf || udf || valley)
      |=> $stable(level));

  // R6: sawtooth overflow with force-high ends high whatever else happened
  a_r6_force_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!tri_mode && ovf && force_sel == 2'd2) |=> level);

  // R3: a slow prescaler turns start low/high into hold
  a_r3_start_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_start && !div1 && !act_start[1] && !cmp_hit && !prd_hit && !cnt_stop
     && !ovf && !udf && !valley) |=> $stable(level));
endmodule

// File: rtl/bpwm_flag.sv
module bpwm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic flag_clr,
  input  logic irq_en,
  input  logic evt_en,
  output logic flag,
  output logic irq,
  output logic evt
);
  logic flag_q, flag_d;
  logic evt_q, evt_d;

  always_comb begin
    flag_d = flag_q;
    if (flag_clr) flag_d = 1'b0;
    if (match)    flag_d = 1'b1;
    evt_d  = match & evt_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      evt_q  <= evt_d;
    end
  end

  assign flag = flag_q;
  assign irq  = flag_q & irq_en;
  assign evt  = evt_q;

  // R10: the flag is sticky until cleared
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);

  // R11: an event pulse is always preceded by an enabled match
  a_r11_event_source: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> $past(match && evt_en));
endmodule

// File: rtl/bpwm_channel.sv
module bpwm_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_tick,
  input  logic             cnt_start,
  input  logic             cnt_stop,
  input  logic             prd_hit,
  input  logic             ovf,
  input  logic             udf,
  input  logic             cnt_clr,
  input  logic             peak,
  input  logic             valley,
  input  logic             tri_mode,
  input  logic             div1,
  input  logic [1:0]       act_start,
  input  logic [1:0]       act_stop,
  input  logic [1:0]       act_cmp,
  input  logic [1:0]       act_prd,
  input  logic [1:0]       force_sel,
  input  logic             out_en,
  input  logic             buf_en,
  input  logic [1:0]       tri_sel,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             buf_wr,
  input  logic [CNT_W-1:0] buf_wdata,
  input  logic             flag_clr,
  input  logic             irq_en,
  input  logic             evt_en,
  output logic             pwm_o,
  output logic [CNT_W-1:0] cmp_val_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             evt_o
);
  logic match;
  logic level;

  bpwm_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .cnt_val(cnt_val),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .buf_wr(buf_wr),
    .buf_wdata(buf_wdata), .buf_en(buf_en), .tri_mode(tri_mode),
    .tri_sel(tri_sel), .ovf(ovf), .udf(udf), .cnt_clr(cnt_clr),
    .peak(peak), .valley(valley), .cmp_act(cmp_val_o), .match(match)
  );

  bpwm_pol u_pol (
    .clk(clk), .rst_n(rst_n), .cnt_start(cnt_start), .cnt_stop(cnt_stop),
    .cmp_hit(match), .prd_hit(prd_hit), .ovf(ovf), .udf(udf),
    .valley(valley), .tri_mode(tri_mode), .div1(div1),
    .act_start(act_start), .act_stop(act_stop), .act_cmp(act_cmp),
    .act_prd(act_prd), .force_sel(force_sel), .level(level)
  );

  bpwm_flag u_flag (
    .clk(clk), .rst_n(rst_n), .match(match), .flag_clr(flag_clr),
    .irq_en(irq_en), .evt_en(evt_en), .flag(flag_o), .irq(irq_o), .evt(evt_o)
  );

  assign pwm_o = out_en & level;
endmodule

// File: tb/bpwm_channel_test.sv
module bpwm_channel_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] cnt_val;
  logic cnt_tick, cnt_start, cnt_stop, prd_hit, ovf, udf, cnt_clr, peak, valley;
  logic tri_mode, div1, out_en, buf_en, cmp_wr, buf_wr, flag_clr, irq_en, evt_en;
  logic [1:0] act_start, act_stop, act_cmp, act_prd, force_sel, tri_sel;
  logic [W-1:0] cmp_wdata, buf_wdata;
  logic pwm_o, flag_o, irq_o, evt_o;
  logic [W-1:0] cmp_val_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bpwm_channel #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_tick(cnt_tick),
    .cnt_start(cnt_start), .cnt_stop(cnt_stop), .prd_hit(prd_hit),
    .ovf(ovf), .udf(udf), .cnt_clr(cnt_clr), .peak(peak), .valley(valley),
    .tri_mode(tri_mode), .div1(div1), .act_start(act_start),
    .act_stop(act_stop), .act_cmp(act_cmp), .act_prd(act_prd),
    .force_sel(force_sel), .out_en(out_en), .buf_en(buf_en),
    .tri_sel(tri_sel), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .buf_wr(buf_wr), .buf_wdata(buf_wdata), .flag_clr(flag_clr),
    .irq_en(irq_en), .evt_en(evt_en), .pwm_o(pwm_o), .cmp_val_o(cmp_val_o),
    .flag_o(flag_o), .irq_o(irq_o), .evt_o(evt_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    cnt_tick = 0; cnt_start = 0; cnt_stop = 0; prd_hit = 0; ovf = 0; udf = 0;
    cnt_clr = 0; peak = 0; valley = 0; cmp_wr = 0; buf_wr = 0; flag_clr = 0;
  endtask

  // set level through a start strobe with divide-by-one
  task automatic set_level(input logic v);
    div1 = 1; act_start = v ? 2'd1 : 2'd0; cnt_start = 1; step();
    act_start = 2'd2;
  endtask

  task automatic t_reset();
    chk("R1 pwm", pwm_o, 0); chk("R1 flag", flag_o, 0);
    chk("R1 irq", irq_o, 0); chk("R1 evt", evt_o, 0);
    chk("R1 cmp", cmp_val_o, 0);
  endtask

  task automatic t_actions();
    cmp_wr = 1; cmp_wdata = 100; step();
    chk("R9 immediate write", cmp_val_o, 100);
    set_level(0);
    act_cmp = 2'd1; cnt_tick = 1; cnt_val = 100; step();
    chk("R2 cmp high", pwm_o, 1);
    act_cmp = 2'd2; cnt_tick = 1; step();
    chk("R2 cmp hold", pwm_o, 1);
    act_cmp = 2'd3; cnt_tick = 1; step();
    chk("R2 cmp invert", pwm_o, 0);
    cnt_tick = 1; step();
    act_cmp = 2'd0; cnt_tick = 1; step();
    chk("R2 cmp low", pwm_o, 0);
    act_cmp = 2'd3; cnt_tick = 1; cnt_val = 99; step();
    chk("R10 no match on other value", pwm_o, 0);
    act_cmp = 2'd2;
  endtask

  task automatic t_start();
    set_level(0);
    div1 = 1; act_start = 2'd1; cnt_start = 1; step();
    chk("R3 start high div1", pwm_o, 1);
    act_start = 2'd0; cnt_start = 1; step();
    chk("R3 start low div1", pwm_o, 0);
    div1 = 0; act_start = 2'd1; cnt_start = 1; step();
    chk("R3 start high ignored slow clock", pwm_o, 0);
    act_start = 2'd3; cnt_start = 1; step();
    chk("R3 start invert slow clock", pwm_o, 1);
    act_start = 2'd0; cnt_start = 1; step();
    chk("R3 start low ignored slow clock", pwm_o, 1);
    div1 = 1; act_start = 2'd2;
  endtask

  task automatic t_stop_prd();
    set_level(0);
    act_stop = 2'd1; cnt_stop = 1; step();
    chk("R4 stop high", pwm_o, 1);
    act_prd = 2'd0; prd_hit = 1; step();
    chk("R4 period low", pwm_o, 0);
    act_prd = 2'd3; prd_hit = 1; step();
    chk("R4 period invert", pwm_o, 1);
    act_stop = 2'd0; cnt_stop = 1; step();
    chk("R4 stop low", pwm_o, 0);
    act_stop = 2'd2; act_prd = 2'd2;
  endtask

  task automatic t_order();
    set_level(0);
    act_cmp = 2'd1; act_prd = 2'd3; cnt_tick = 1; cnt_val = 100; prd_hit = 1; step();
    chk("R5 high then invert", pwm_o, 0);
    set_level(0);
    act_cmp = 2'd3; act_prd = 2'd1; cnt_tick = 1; prd_hit = 1; step();
    chk("R5 invert then high", pwm_o, 1);
    act_cmp = 2'd2; act_prd = 2'd2;
  endtask

  task automatic t_force();
    set_level(1);
    tri_mode = 0; force_sel = 2'd1; step();
    chk("R6 no boundary no force", pwm_o, 1);
    ovf = 1; step();
    chk("R6 force low on overflow", pwm_o, 0);
    force_sel = 2'd2; udf = 1; step();
    chk("R6 force high on underflow", pwm_o, 1);
    force_sel = 2'd1; tri_mode = 1; ovf = 1; step();
    chk("R6 triangle overflow not boundary", pwm_o, 1);
    valley = 1; step();
    chk("R6 force low on valley", pwm_o, 0);
    tri_mode = 0; force_sel = 2'd3; ovf = 1; step();
    chk("R6 code 3 is none", pwm_o, 0);
    force_sel = 2'd2; act_prd = 2'd0; prd_hit = 1; ovf = 1; step();
    chk("R6 force overrides period action", pwm_o, 1);
    force_sel = 2'd0; act_prd = 2'd2;
  endtask

  task automatic t_buf_saw();
    buf_en = 1; tri_mode = 0;
    buf_wr = 1; buf_wdata = 200; step();
    chk("R7 buffer write not active", cmp_val_o, 100);
    ovf = 1; step();
    chk("R7 overflow transfer", cmp_val_o, 200);
    buf_wr = 1; buf_wdata = 300; step();
    udf = 1; step();
    chk("R7 underflow transfer", cmp_val_o, 300);
    buf_wr = 1; buf_wdata = 400; step();
    cnt_clr = 1; step();
    chk("R7 clear transfer", cmp_val_o, 400);
  endtask

  task automatic t_buf_tri();
    tri_mode = 1; tri_sel = 2'b01;
    buf_wr = 1; buf_wdata = 500; step();
    valley = 1; step();
    chk("R8 valley disabled", cmp_val_o, 400);
    peak = 1; step();
    chk("R8 peak transfer", cmp_val_o, 500);
    tri_sel = 2'b10; buf_wr = 1; buf_wdata = 600; step();
    peak = 1; step();
    chk("R8 peak disabled", cmp_val_o, 500);
    valley = 1; step();
    chk("R8 valley transfer", cmp_val_o, 600);
    tri_sel = 2'b11; buf_wr = 1; buf_wdata = 700; step();
    peak = 1; step();
    chk("R8 both peak", cmp_val_o, 700);
    buf_wr = 1; buf_wdata = 800; step();
    valley = 1; step();
    chk("R8 both valley", cmp_val_o, 800);
    tri_sel = 2'b00; buf_wr = 1; buf_wdata = 900; step();
    ovf = 1; udf = 1; cnt_clr = 1; peak = 1; valley = 1; step();
    chk("R8 none selected", cmp_val_o, 800);
    tri_mode = 0; force_sel = 2'd0;
  endtask

  task automatic t_nobuf();
    buf_en = 0; tri_mode = 0;
    buf_wr = 1; buf_wdata = 1000; step();
    ovf = 1; step();
    chk("R9 no transfer unbuffered", cmp_val_o, 800);
    buf_en = 1; cmp_wr = 1; cmp_wdata = 50; ovf = 1; step();
    chk("R9 write beats transfer", cmp_val_o, 50);
    buf_en = 0; cmp_wr = 1; cmp_wdata = 50; step();
  endtask

  task automatic t_flag();
    flag_clr = 1; step();
    chk("R10 flag clear", flag_o, 0);
    irq_en = 1; evt_en = 1; cnt_tick = 1; cnt_val = 50; step();
    chk("R10 flag set", flag_o, 1);
    chk("R11 irq", irq_o, 1);
    chk("R11 evt pulse", evt_o, 1);
    step();
    chk("R11 evt one cycle", evt_o, 0);
    chk("R10 flag sticky", flag_o, 1);
    flag_clr = 1; cnt_tick = 1; step();
    chk("R10 set beats clear", flag_o, 1);
    flag_clr = 1; step();
    chk("R11 irq drops", irq_o, 0);
    irq_en = 0; evt_en = 0; cnt_tick = 1; step();
    chk("R11 evt disabled", evt_o, 0);
    chk("R11 irq masked", irq_o, 0);
    flag_clr = 1; step();
    cnt_tick = 0; cnt_val = 50; step();
    chk("R10 no tick no match", flag_o, 0);
  endtask

  task automatic t_gate();
    set_level(0);
    out_en = 0; act_cmp = 2'd1; cnt_tick = 1; cnt_val = 50; step();
    chk("R12 gated low", pwm_o, 0);
    out_en = 1; #1;
    chk("R12 state kept updating", pwm_o, 1);
    out_en = 0; act_cmp = 2'd3; cnt_tick = 1; step();
    chk("R12 gated after invert", pwm_o, 0);
    out_en = 1; #1;
    chk("R12 inverted level shown", pwm_o, 0);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", cyc, 20000);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 0; cnt_val = 0; cnt_tick = 0; cnt_start = 0; cnt_stop = 0;
    prd_hit = 0; ovf = 0; udf = 0; cnt_clr = 0; peak = 0; valley = 0;
    tri_mode = 0; div1 = 1; out_en = 1; buf_en = 0; cmp_wr = 0; buf_wr = 0;
    flag_clr = 0; irq_en = 0; evt_en = 0;
    act_start = 2'd2; act_stop = 2'd2; act_cmp = 2'd2; act_prd = 2'd2;
    force_sel = 2'd0; tri_sel = 2'd0; cmp_wdata = 0; buf_wdata = 0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_actions();
    t_start();
    t_stop_prd();
    t_order();
    t_force();
    t_buf_saw();
    t_buf_tri();
    t_nobuf();
    t_flag();
    t_gate();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule